// File: doc/BRIEF.md
# Scheduled Mesh Tile Switch

This block is the word switch for one tile of a two-dimensional mesh. It has five 32-bit ports: four neighbour links (north, south, east, west) and the tile's own processor. Which input feeds which output is not decided by packet contents. A route program, compiled ahead of time and held in a small local memory, decides it. Each program step names a source for every output, or leaves that output idle. The switch works through the program one step after another, so the words on every link come out in an order that is known before run time.

Every input lands in a registered FIFO, so no path from a neighbour's link reaches deeper than this tile. A step retires in a single cycle, and only when every FIFO it reads holds a word and every output it drives has room downstream. Until then the step waits, and no word moves and no FIFO is popped. One input may feed several outputs in the same step. A jump bit in the step sends the program counter back to a stored address, so that a schedule can repeat.

The program memory has a simple write port. It is normally filled while reset is held. Reset puts the program counter at address 0 and empties all input FIFOs.

Top module: `static_route_switch`

## Requirements
- R1: While reset is high and in the first cycle after it falls, every in_ready bit is 1 and every out_valid bit is 0, and execution starts at program address 0.
- R2: A program word holds, from bit 0 upward, five 3-bit source codes, one for each output in port order north=0, south=1, east=2, west=3, local=4 (output p at bits 3p+2..3p). Next comes a jump bit (bit 15), then the jump target address in the bits above it. The source codes 0 to 4 name the input port with that index, and code 7 means no transfer.
- R3: When a step retires, each output that has a source code drives that input's oldest word on out_data, with out_valid high, in that same cycle.
- R4: One input selected by several outputs in a step delivers the same word to all of them, and is popped once.
- R5: A step whose selected inputs are not all non-empty, or whose selected outputs do not all have out_ready high, holds: all out_valid bits stay 0, no FIFO is popped and the program counter does not move.
- R6: A retired step without its jump bit advances the program counter by one, wrapping from the last address to 0. A step that selects no source for any output retires at once.
- R7: A retired step with its jump bit set loads the program counter with its target address.
- R8: Each input FIFO keeps word order and holds FIFO_DEPTH words. in_ready falls when it is full, and a word offered while in_ready is low is not taken.
- R9: A word accepted on an input in cycle t can leave on an output no earlier than cycle t+1. A steady schedule moves one word per cycle per port.
- R10: An output whose source code is 7 keeps out_valid low whenever a step retires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program memory write strobe |
| prog_addr | input | 5 | Program memory write address (log2 of PROG_DEPTH) |
| prog_wdata | input | 21 | Program word: source codes, jump bit, jump target |
| in_valid | input | 5 | Per-port input word offered |
| in_data | input | 160 | Input words, port p at bits 32p+31..32p |
| in_ready | output | 5 | Per-port input FIFO has room |
| out_valid | output | 5 | Per-port output word present this cycle |
| out_data | output | 160 | Output words, port p at bits 32p+31..32p |
| out_ready | input | 5 | Per-port downstream has room |

## Verification
The assertions assume that the FIFO read strobes from the sequencer only name FIFOs that hold a word. They also assume that the program memory is written before the steps it holds are fetched. The bench writes every address of the program memory while reset is held, before each scenario. It offers new words only on ports its schedule will later drain, and it lowers out_ready only on outputs whose stalls it means to observe. The routing sweep covers every source and destination pair, one word at a time. Separate scenarios cover fan-out with a jump, FIFO fill past capacity, and a program counter that wraps.

// File: rtl/rt_pkg.sv
package rt_pkg;
    localparam int NPORT  = 5;
    localparam int SRC_W  = 3;
    typedef logic [SRC_W-1:0] src_t;
    localparam src_t SRC_NONE = 3'd7;

    // One step of the route program: per output a source code, plus loop flag
    typedef struct packed {
        logic                  jump;
        src_t [NPORT-1:0]      sel;
    } step_t;
    localparam int STEP_W = 1 + NPORT * SRC_W;

    function automatic logic names_port(src_t code);
        return code < src_t'(NPORT);
    endfunction
endpackage

// File: rtl/rt_in_fifo.sv
module rt_in_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_valid,
    output logic         push_ready,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         head_valid,
    output logic [W-1:0] head_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push;

    assign push_ready = (count != CW'(DEPTH));
    assign push       = push_valid && push_ready;
    assign head_valid = (count != '0);
    assign head_data  = store[rd_ptr];

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)) else $error("fifo count beyond depth"); // R8
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> head_valid) else $error("pop of empty fifo"); // R5
    AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> push_ready) else $error("fifo not ready after reset"); // R1
endmodule

// File: rtl/rt_route_mem.sv
module rt_route_mem #(
    parameter int DEPTH = 32,
    parameter int DW    = 21
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) words[waddr] <= wdata;
    end

    assign rdata = words[raddr];
endmodule

// File: rtl/rt_sequencer.sv
module rt_sequencer
    import rt_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  step_t            step,
    input  logic [AW-1:0]    target,
    input  logic [NPORT-1:0] head_valid,
    input  logic [NPORT-1:0] out_ready,
    output logic [AW-1:0]    pc,
    output logic [NPORT-1:0] pop,
    output logic [NPORT-1:0] out_valid
);
    logic [NPORT-1:0] need_src;
    logic [NPORT-1:0] need_dst;
    logic             fire;

    always_comb begin
        need_src = '0;
        need_dst = '0;
        for (int o = 0; o < NPORT; o++) begin
            need_dst[o] = names_port(step.sel[o]);
            for (int i = 0; i < NPORT; i++) begin
                if (step.sel[o] == src_t'(i)) need_src[i] = 1'b1;
            end
        end
    end

    assign fire      = (&(head_valid | ~need_src)) && (&(out_ready | ~need_dst));
    assign pop       = need_src & {NPORT{fire}};
    assign out_valid = need_dst & {NPORT{fire}};

    always_ff @(posedge clk) begin
        if (rst)           pc <= '0;
        else if (fire)     pc <= step.jump ? target : pc + AW'(1);
    end

    AST_PC_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pc == '0) else $error("pc not at 0 after reset"); // R1
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(pc)) else $error("pc moved on stalled step"); // R5
endmodule

// File: rtl/rt_crossbar.sv
module rt_crossbar
    import rt_pkg::*;
#(
    parameter int W = 32
) (
    input  step_t              step,
    input  logic [NPORT*W-1:0] heads,
    output logic [NPORT*W-1:0] outs
);
    logic [W-1:0] head_arr [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_unpack
        assign head_arr[p] = heads[p*W +: W];
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        always_comb begin
            outs[o*W +: W] = '0;
            for (int i = 0; i < NPORT; i++) begin
                if (step.sel[o] == src_t'(i)) outs[o*W +: W] = head_arr[i];
            end
        end
    end
endmodule

// File: rtl/static_route_switch.sv
module static_route_switch
    import rt_pkg::*;
#(
    parameter int W          = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int PROG_DEPTH = 32,
    localparam int AW        = $clog2(PROG_DEPTH),
    localparam int IW        = STEP_W + AW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               prog_we,
    input  logic [AW-1:0]      prog_addr,
    input  logic [IW-1:0]      prog_wdata,
    input  logic [NPORT-1:0]   in_valid,
    input  logic [NPORT*W-1:0] in_data,
    output logic [NPORT-1:0]   in_ready,
    output logic [NPORT-1:0]   out_valid,
    output logic [NPORT*W-1:0] out_data,
    input  logic [NPORT-1:0]   out_ready
);
    logic [AW-1:0]      pc;
    logic [IW-1:0]      word;
    step_t              step;
    logic [AW-1:0]      target;
    logic [NPORT-1:0]   head_valid;
    logic [NPORT-1:0]   pop;
    logic [NPORT*W-1:0] heads;

    assign step   = step_t'(word[STEP_W-1:0]);
    assign target = word[IW-1:STEP_W];

    rt_route_mem #(.DEPTH(PROG_DEPTH), .DW(IW)) u_mem (
        .clk   (clk),
        .we    (prog_we),
        .waddr (prog_addr),
        .wdata (prog_wdata),
        .raddr (pc),
        .rdata (word)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_in
        rt_in_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk        (clk),
            .rst        (rst),
            .push_valid (in_valid[p]),
            .push_ready (in_ready[p]),
            .push_data  (in_data[p*W +: W]),
            .pop        (pop[p]),
            .head_valid (head_valid[p]),
            .head_data  (heads[p*W +: W])
        );
    end

    rt_sequencer #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .target     (target),
        .head_valid (head_valid),
        .out_ready  (out_ready),
        .pc         (pc),
        .pop        (pop),
        .out_valid  (out_valid)
    );

    rt_crossbar #(.W(W)) u_xbar (
        .step  (step),
        .heads (heads),
        .outs  (out_data)
    );
endmodule

// File: tb/tb_static_route_switch.sv
module tb_static_route_switch;
    localparam int W  = 32;
    localparam int NP = 5;
    localparam int FD = 4;
    localparam int PD = 32;
    localparam int AW = 5;
    localparam int IW = 21;
    localparam logic [2:0] NONE = 3'd7;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            prog_we = 1'b0;
    logic [AW-1:0]   prog_addr = '0;
    logic [IW-1:0]   prog_wdata = '0;
    logic [NP-1:0]   in_valid = '0;
    logic [NP*W-1:0] in_data = '0;
    logic [NP-1:0]   in_ready;
    logic [NP-1:0]   out_valid;
    logic [NP*W-1:0] out_data;
    logic [NP-1:0]   out_ready = '1;

    int checks = 0;
    int failures = 0;
    logic [IW-1:0] prog [PD];

    always #2.5 clk = ~clk;

    static_route_switch #(.W(W), .FIFO_DEPTH(FD), .PROG_DEPTH(PD)) dut (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_wdata(prog_wdata), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Program word: source code for output p at [3p+:3], jump at 15, target above
    function automatic logic [IW-1:0] mk(input logic [2:0] sn, input logic [2:0] ss, input logic [2:0] se,
                                         input logic [2:0] sw, input logic [2:0] sl,
                                         input logic jmp, input logic [AW-1:0] tgt);
        return {tgt, jmp, sl, sw, se, ss, sn};
    endfunction

    function automatic logic [IW-1:0] one_route(input int src, input int dst);
        logic [2:0] s [NP];
        for (int k = 0; k < NP; k++) s[k] = NONE;
        s[dst] = 3'(src);
        return mk(s[0], s[1], s[2], s[3], s[4], 1'b0, '0);
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] odat(input int p);
        return out_data[p*W +: W];
    endfunction

    // Loads prog[] while reset is held, then releases reset
    task automatic load_and_start();
        rst = 1'b1;
        in_valid = '0;
        out_ready = '1;
        for (int a = 0; a < PD; a++) begin
            cyc();
            prog_we = 1'b1;
            prog_addr = AW'(a);
            prog_wdata = prog[a];
        end
        cyc();
        prog_we = 1'b0;
        cyc();
        rst = 1'b0;
    endtask

    task automatic clear_prog();
        for (int a = 0; a < PD; a++) prog[a] = mk(NONE, NONE, NONE, NONE, NONE, 1'b0, '0);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] pat;
        // ---- R1 reset state and R3/R9/R10 sweep over all source/dest pairs
        clear_prog();
        for (int i = 0; i < NP*NP; i++) prog[i] = one_route(i / NP, i % NP);
        load_and_start();
        #1;
        chk(in_ready == 5'h1f, "R1 in_ready after reset", 32'(in_ready), 32'h1f);
        chk(out_valid == 5'h00, "R1 out_valid after reset", 32'(out_valid), 32'h0);
        for (int i = 0; i < NP*NP; i++) begin
            pat = 32'hA500_0000 | (i << 8) | (i / NP);
            cyc();
            in_valid = 5'(1 << (i / NP));
            in_data[(i / NP)*W +: W] = pat;
            #1;
            chk(out_valid == 5'h00, "R9 no same-cycle pass", 32'(out_valid), 32'h0);
            cyc();
            in_valid = '0;
            #1;
            chk(out_valid == 5'(1 << (i % NP)), "R3 R10 valid mask", 32'(out_valid), 32'(1 << (i % NP)));
            chk(odat(i % NP) == pat, "R3 routed word", odat(i % NP), pat);
        end

        // ---- R4 fan-out, R5 stalls, R2 R7 jump
        clear_prog();
        prog[0] = mk(3'd4, 3'd4, 3'd4, NONE, NONE, 1'b0, '0);
        prog[1] = mk(NONE, NONE, NONE, NONE, 3'd0, 1'b1, 5'd0);
        prog[2] = mk(NONE, NONE, NONE, 3'd0, NONE, 1'b0, '0);
        load_and_start();
        cyc();
        out_ready = 5'b11101;
        in_valid = 5'b10000;
        in_data[4*W +: W] = 32'h1111_2222;
        #1;
        chk(out_valid == 5'h00, "R9 fanout source not yet present", 32'(out_valid), 32'h0);
        for (int k = 0; k < 3; k++) begin
            cyc();
            in_valid = '0;
            #1;
            chk(out_valid == 5'h00, "R5 hold on full destination", 32'(out_valid), 32'h0);
        end
        cyc();
        out_ready = '1;
        #1;
        chk(out_valid == 5'b00111, "R4 fanout mask", 32'(out_valid), 32'h7);
        chk(odat(0) == 32'h1111_2222 && odat(1) == 32'h1111_2222 && odat(2) == 32'h1111_2222,
            "R4 fanout data", odat(1), 32'h1111_2222);
        cyc();
        #1;
        chk(out_valid == 5'h00, "R5 hold on empty source", 32'(out_valid), 32'h0);
        chk(in_ready == 5'h1f, "R4 single pop leaves room", 32'(in_ready), 32'h1f);
        in_valid = 5'b00001;
        in_data[0 +: W] = 32'h3333_4444;
        cyc();
        in_valid = '0;
        #1;
        chk(out_valid == 5'b10000, "R3 north to local mask", 32'(out_valid), 32'h10);
        chk(odat(4) == 32'h3333_4444, "R3 north to local data", odat(4), 32'h3333_4444);
        cyc();
        in_valid = 5'b10000;
        in_data[4*W +: W] = 32'h5555_6666;
        cyc();
        in_valid = '0;
        #1;
        chk(out_valid == 5'b00111, "R2 R7 jump back to 0", 32'(out_valid), 32'h7);
        chk(odat(2) == 32'h5555_6666, "R7 jump data", odat(2), 32'h5555_6666);

        // ---- R8 fill past capacity, order, R9 throughput
        clear_prog();
        prog[0] = mk(NONE, NONE, 3'd3, NONE, NONE, 1'b1, 5'd0);
        load_and_start();
        out_ready = 5'b11011;
        for (int k = 0; k <= FD; k++) begin
            cyc();
            in_valid = 5'b01000;
            in_data[3*W +: W] = 32'hD000_0000 + 32'(k);
            #1;
            chk(in_ready[3] == (k < FD), "R8 in_ready vs fill", 32'(in_ready[3]), 32'(k < FD));
            chk(out_valid == 5'h00, "R5 hold while east blocked", 32'(out_valid), 32'h0);
        end
        cyc();
        in_valid = '0;
        out_ready = '1;
        for (int k = 0; k < FD; k++) begin
            #1;
            chk(out_valid == 5'b00100, "R9 one word per cycle", 32'(out_valid), 32'h4);
            chk(odat(2) == 32'hD000_0000 + 32'(k), "R8 word order", odat(2), 32'hD000_0000 + 32'(k));
            cyc();
        end
        #1;
        chk(out_valid == 5'h00, "R8 refused word not stored", 32'(out_valid), 32'h0);

        // ---- R6 sequential advance, empty steps, wrap to 0
        clear_prog();
        prog[0]  = mk(NONE, NONE, 3'd1, NONE, NONE, 1'b0, '0);
        prog[31] = mk(NONE, NONE, NONE, NONE, 3'd0, 1'b0, '0);
        load_and_start();
        in_valid = 5'b00010;
        in_data[1*W +: W] = 32'hE000_0001;
        cyc();
        in_valid = '0;
        #1;
        chk(out_valid == 5'b00100 && odat(2) == 32'hE000_0001, "R6 start at address 0", odat(2), 32'hE000_0001);
        for (int k = 0; k < 40; k++) cyc();
        in_valid = 5'b00001;
        in_data[0 +: W] = 32'hE000_0002;
        cyc();
        in_valid = '0;
        #1;
        chk(out_valid == 5'b10000 && odat(4) == 32'hE000_0002, "R6 reached last address", odat(4), 32'hE000_0002);
        in_valid = 5'b00010;
        in_data[1*W +: W] = 32'hE000_0003;
        cyc();
        in_valid = '0;
        #1;
        chk(out_valid == 5'b00100 && odat(2) == 32'hE000_0003, "R6 wrap to 0", odat(2), 32'hE000_0003);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule